// File: doc/BRIEF.md
# Single-Cycle 64-bit Load/Store Core

This core runs one instruction per clock from a small 64-bit subset. The subset has four register-to-register operations (add, subtract, bitwise and, bitwise or), two immediate arithmetic forms, a doubleword load, a doubleword store, an unconditional relative branch and a compare-with-zero conditional branch. In each cycle the core reads a 32-bit word from its instruction array at the current program counter. It decodes the opcode into control terms, reads two operands from a 32-entry register file and extends the immediate field for the instruction's format. It then computes the result with a small ALU, reads or writes its data array, and writes the result back. The new program counter is taken at the same clock edge.

Both arrays sit inside the core. A loading port writes them one word at a time, and it is normally used while reset holds the core. The execution results appear on the output ports every cycle as a trace: the program counter, the instruction, the next program counter, the register write and the memory write. An integrator can therefore check a program without looking inside the core.

The core has no sequencer. The only state is the program counter, the register file and the two arrays. Reset is asynchronous and active low. It clears the program counter and every register. While reset is low, no register or data write is issued.

Top module: `sc_core64`

## Requirements
- R1: While rst_n is low, pc_o is 0, rf_we_o and dm_we_o are 0, and all registers are cleared. After a reset, every register reads as 0.
- R2: The opcode bits [31:21] are decoded by prefix. Eleven-bit codes: add 10001011000, subtract 11001011000, and 10001010000, or 10101010000, load 11111000010, store 11111000000. Ten-bit codes: add-immediate 1001000100, subtract-immediate 1101000100. Eight-bit code: compare-zero branch 10110100. Six-bit code: branch 000101.
- R3: The first operand register is bits [9:5]. The second is bits [20:16], except for load, store and compare-zero branch, which take it from bits [4:0]. The destination is always bits [4:0].
- R4: Immediate extension to 64 bits works as follows. Add- and subtract-immediate zero-extend bits [21:10]. Load and store sign-extend bits [20:12]. Compare-zero branch sign-extends bits [23:5]. Branch sign-extends bits [25:0].
- R5: The ALU computes and, or, add, and subtract as A plus the two's complement of B, all modulo 2^64. It also has a pass-B mode. The zero flag is set when the result is all zeros.
- R6: The load/store address is the first operand plus the sign-extended offset. A load returns the 64-bit word at address[..:3]. A store writes the second operand there, and a later load of that address returns the stored value.
- R7: Register 31 always reads as 0, and a write to it is discarded.
- R8: The next PC is PC+4. It is PC + (immediate << 2) for a branch, and also for a compare-zero branch whose register equals 0.
- R9: The write-back value is the load data for a load and the ALU result otherwise. Register writes occur only for the six arithmetic/logic operations and the load. Memory writes occur only for the store.
- R10: Any opcode that matches none of the codes in R2 writes no register and no memory, and advances the PC by 4.
- R11: The mask-and-count program below runs from reset and completes in 50 cycles. It masks the low nibble of 0x123456789ABCEDFA (giving 0xA) by or-ing 0xA and 5 into a mask, then counts down to 0. It stores the count 0xA at byte address 0x20 and reloads it into register 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we_i | input | 1 | Write one word into an internal array |
| prog_dmem_i | input | 1 | 1 selects the data array, 0 the instruction array |
| prog_addr_i | input | log2(MEM_WORDS) | Word index for the load |
| prog_data_i | input | 64 | Load data (low 32 bits for instructions) |
| pc_o | output | 64 | Current program counter |
| instr_o | output | 32 | Instruction at pc_o |
| next_pc_o | output | 64 | Program counter taken at the next edge |
| rf_we_o | output | 1 | Register write issued this cycle |
| rf_waddr_o | output | 5 | Destination register |
| rf_wdata_o | output | 64 | Write-back value |
| dm_we_o | output | 1 | Data write issued this cycle |
| dm_addr_o | output | 64 | Data byte address (ALU result) |
| dm_wdata_o | output | 64 | Store data |

## Verification
The bench checks that an offset of -8 sign-extends while the 12-bit immediate 0xFFF does not. A core that swapped these extensions would load from the wrong word and add 0xFFFF_FFFF_FFFF_FFFF. The bench writes register 31 and then reads it. It also checks that a store is issued using the destination field as its data source, because a core that took the second operand from bits [20:16] would store the wrong register. Branches are checked both taken and not taken, with forward and backward offsets, which exposes a missing left shift or a lost sign bit. An all-zero opcode must leave the register file and the data array unchanged.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN     = 64;
    localparam int ILEN     = 32;
    localparam int NREG     = 32;
    localparam int RIDX_W   = $clog2(NREG);
    localparam int ZERO_IDX = NREG - 1;
    localparam int OPC_W    = 11;

    localparam int IMM_I_W  = 12;
    localparam int IMM_D_W  = 9;
    localparam int IMM_CB_W = 19;
    localparam int IMM_B_W  = 26;

    localparam logic [10:0] OPC_ADD  = 11'b10001011000;
    localparam logic [10:0] OPC_SUB  = 11'b11001011000;
    localparam logic [10:0] OPC_AND  = 11'b10001010000;
    localparam logic [10:0] OPC_ORR  = 11'b10101010000;
    localparam logic [10:0] OPC_LD   = 11'b11111000010;
    localparam logic [10:0] OPC_ST   = 11'b11111000000;
    localparam logic [9:0]  OPC_ADDI = 10'b1001000100;
    localparam logic [9:0]  OPC_SUBI = 10'b1101000100;
    localparam logic [7:0]  OPC_CBZ  = 8'b10110100;
    localparam logic [5:0]  OPC_BR   = 6'b000101;

    typedef enum logic [3:0] {
        ALU_AND   = 4'b0000,
        ALU_ORR   = 4'b0001,
        ALU_ADD   = 4'b0010,
        ALU_SUB   = 4'b0011,
        ALU_PASSB = 4'b0100
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_I  = 2'd0,
        IMM_D  = 2'd1,
        IMM_CB = 2'd2,
        IMM_B  = 2'd3
    } imm_fmt_e;

    typedef struct packed {
        logic     take_cond;
        logic     take_always;
        logic     mem_rd;
        logic     mem_we;
        logic     wb_from_mem;
        logic     rm_from_rd;
        logic     use_imm;
        logic     reg_we;
        alu_op_e  alu;
        imm_fmt_e fmt;
    } ctl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    output ctl_t             ctl_o
);
    always_comb begin
        ctl_o     = '0;
        ctl_o.alu = ALU_AND;
        ctl_o.fmt = IMM_I;
        if (opc_i == OPC_ADD || opc_i == OPC_SUB ||
            opc_i == OPC_AND || opc_i == OPC_ORR) begin
            ctl_o.reg_we = 1'b1;
            if (opc_i == OPC_ADD)      ctl_o.alu = ALU_ADD;
            else if (opc_i == OPC_SUB) ctl_o.alu = ALU_SUB;
            else if (opc_i == OPC_AND) ctl_o.alu = ALU_AND;
            else                       ctl_o.alu = ALU_ORR;
        end else if (opc_i == OPC_LD) begin
            ctl_o.mem_rd      = 1'b1;
            ctl_o.wb_from_mem = 1'b1;
            ctl_o.rm_from_rd  = 1'b1;
            ctl_o.use_imm     = 1'b1;
            ctl_o.reg_we      = 1'b1;
            ctl_o.alu         = ALU_ADD;
            ctl_o.fmt         = IMM_D;
        end else if (opc_i == OPC_ST) begin
            ctl_o.mem_we     = 1'b1;
            ctl_o.rm_from_rd = 1'b1;
            ctl_o.use_imm    = 1'b1;
            ctl_o.alu        = ALU_ADD;
            ctl_o.fmt        = IMM_D;
        end else if (opc_i[10:1] == OPC_ADDI || opc_i[10:1] == OPC_SUBI) begin
            ctl_o.use_imm = 1'b1;
            ctl_o.reg_we  = 1'b1;
            ctl_o.alu     = (opc_i[10:1] == OPC_ADDI) ? ALU_ADD : ALU_SUB;
            ctl_o.fmt     = IMM_I;
        end else if (opc_i[10:3] == OPC_CBZ) begin
            ctl_o.take_cond  = 1'b1;
            ctl_o.rm_from_rd = 1'b1;
            ctl_o.alu        = ALU_PASSB;
            ctl_o.fmt        = IMM_CB;
        end else if (opc_i[10:5] == OPC_BR) begin
            ctl_o.take_always = 1'b1;
            ctl_o.fmt         = IMM_B;
        end
    end
endmodule

// File: rtl/sc_immext.sv
module sc_immext
    import sc_pkg::*;
(
    input  logic [IMM_B_W-1:0] field_i,
    input  imm_fmt_e           fmt_i,
    output logic [XLEN-1:0]    imm_o
);
    localparam int I_LO  = 10;
    localparam int D_LO  = 12;
    localparam int CB_LO = 5;

    always_comb begin
        unique case (fmt_i)
            IMM_I:  imm_o = {{(XLEN-IMM_I_W){1'b0}}, field_i[I_LO +: IMM_I_W]};
            IMM_D:  imm_o = {{(XLEN-IMM_D_W){field_i[D_LO+IMM_D_W-1]}},
                             field_i[D_LO +: IMM_D_W]};
            IMM_CB: imm_o = {{(XLEN-IMM_CB_W){field_i[CB_LO+IMM_CB_W-1]}},
                             field_i[CB_LO +: IMM_CB_W]};
            default: imm_o = {{(XLEN-IMM_B_W){field_i[IMM_B_W-1]}}, field_i};
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
(
    input  alu_op_e         op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] res_o,
    output logic            zero_o
);
    always_comb begin
        unique case (op_i)
            ALU_AND:   res_o = a_i & b_i;
            ALU_ORR:   res_o = a_i | b_i;
            ALU_ADD:   res_o = a_i + b_i;
            ALU_SUB:   res_o = a_i + (~b_i + {{(XLEN-1){1'b0}}, 1'b1});
            ALU_PASSB: res_o = b_i;
            default:   res_o = '0;
        endcase
        zero_o = (res_o == '0);
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] ra_i,
    input  logic [RIDX_W-1:0] rb_i,
    output logic [XLEN-1:0]   da_o,
    output logic [XLEN-1:0]   db_o,
    input  logic              we_i,
    input  logic [RIDX_W-1:0] wa_i,
    input  logic [XLEN-1:0]   wd_i
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we_i && wa_i != RIDX_W'(ZERO_IDX)) begin
            regs[wa_i] <= wd_i;
        end
    end

    assign da_o = (ra_i == RIDX_W'(ZERO_IDX)) ? '0 : regs[ra_i];
    assign db_o = (rb_i == RIDX_W'(ZERO_IDX)) ? '0 : regs[rb_i];

    // R7: the storage behind the zero register never takes a value
    assert_zero_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        regs[ZERO_IDX] == '0)
        else $error("zero register storage was written");
endmodule

// File: rtl/sc_core64.sv
module sc_core64
    import sc_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    localparam int MAW      = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_we_i,
    input  logic              prog_dmem_i,
    input  logic [MAW-1:0]    prog_addr_i,
    input  logic [XLEN-1:0]   prog_data_i,
    output logic [XLEN-1:0]   pc_o,
    output logic [ILEN-1:0]   instr_o,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              rf_we_o,
    output logic [RIDX_W-1:0] rf_waddr_o,
    output logic [XLEN-1:0]   rf_wdata_o,
    output logic              dm_we_o,
    output logic [XLEN-1:0]   dm_addr_o,
    output logic [XLEN-1:0]   dm_wdata_o
);
    logic [ILEN-1:0] imem [MEM_WORDS];
    logic [XLEN-1:0] dmem [MEM_WORDS];

    logic [XLEN-1:0]   pc_q;
    logic [ILEN-1:0]   instr;
    ctl_t              ctl;
    logic [RIDX_W-1:0] rb_sel;
    logic [XLEN-1:0]   da, db, imm, opb, alu_res, ld_data, wb_data, target;
    logic              alu_zero, taken;

    assign instr = imem[pc_q[2 +: MAW]];

    sc_decode u_decode (.opc_i(instr[ILEN-1 -: OPC_W]), .ctl_o(ctl));

    assign rb_sel = ctl.rm_from_rd ? instr[4:0] : instr[20:16];

    sc_regfile u_regfile (
        .clk(clk), .rst_n(rst_n),
        .ra_i(instr[9:5]), .rb_i(rb_sel),
        .da_o(da), .db_o(db),
        .we_i(rf_we_o), .wa_i(instr[4:0]), .wd_i(wb_data)
    );

    sc_immext u_immext (.field_i(instr[IMM_B_W-1:0]), .fmt_i(ctl.fmt), .imm_o(imm));

    assign opb = ctl.use_imm ? imm : db;

    sc_alu u_alu (.op_i(ctl.alu), .a_i(da), .b_i(opb), .res_o(alu_res), .zero_o(alu_zero));

    assign ld_data = ctl.mem_rd ? dmem[alu_res[3 +: MAW]] : '0;
    assign wb_data = ctl.wb_from_mem ? ld_data : alu_res;
    assign taken   = ctl.take_always | (ctl.take_cond & alu_zero);
    assign target  = pc_q + {imm[XLEN-3:0], 2'b00};
    assign next_pc_o = taken ? target : pc_q + XLEN'(4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= next_pc_o;
    end

    always_ff @(posedge clk) begin
        if (prog_we_i && !prog_dmem_i) imem[prog_addr_i] <= prog_data_i[ILEN-1:0];
        if (dm_we_o)                   dmem[alu_res[3 +: MAW]] <= db;
        if (prog_we_i && prog_dmem_i)  dmem[prog_addr_i] <= prog_data_i;
    end

    assign pc_o       = pc_q;
    assign instr_o    = instr;
    assign rf_we_o    = ctl.reg_we & rst_n;
    assign rf_waddr_o = instr[4:0];
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = ctl.mem_we & rst_n;
    assign dm_addr_o  = alu_res;
    assign dm_wdata_o = db;

    assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |=> pc_q == $past(pc_q) + XLEN'(4))
        else $error("sequential step did not add 4");
    assert_pc_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> pc_q == $past(target))
        else $error("taken branch missed its target");
    assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_we_o && dm_we_o))
        else $error("register and memory written together");
    assert_load_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.wb_from_mem |-> ctl.reg_we)
        else $error("load data selected without a register write");
endmodule

// File: tb/test_sc_core64.sv
`timescale 1ns/1ps
module test_sc_core64;
    localparam logic [10:0] T_ADD = 11'b10001011000, T_SUB = 11'b11001011000;
    localparam logic [10:0] T_AND = 11'b10001010000, T_ORR = 11'b10101010000;
    localparam logic [10:0] T_LD  = 11'b11111000010, T_ST  = 11'b11111000000;
    localparam logic [9:0]  T_ADDI = 10'b1001000100, T_SUBI = 10'b1101000100;
    localparam logic [7:0]  T_CBZ = 8'b10110100;
    localparam logic [5:0]  T_BR  = 6'b000101;

    function automatic logic [31:0] enc_r(logic [10:0] op, int rm, int rn, int rd);
        return {op, rm[4:0], 6'd0, rn[4:0], rd[4:0]};
    endfunction
    function automatic logic [31:0] enc_i(logic [9:0] op, int imm, int rn, int rd);
        return {op, imm[11:0], rn[4:0], rd[4:0]};
    endfunction
    function automatic logic [31:0] enc_d(logic [10:0] op, int off, int rn, int rt);
        return {op, off[8:0], 2'b00, rn[4:0], rt[4:0]};
    endfunction
    function automatic logic [31:0] enc_cb(int off, int rt);
        return {T_CBZ, off[18:0], rt[4:0]};
    endfunction
    function automatic logic [31:0] enc_b(int off);
        return {T_BR, off[25:0]};
    endfunction

    typedef struct packed {
        logic [63:0] pc;
        logic [31:0] ins;
        logic        we;
        logic [4:0]  rd;
        logic [63:0] wd;
        logic        mwe;
        logic [63:0] maddr;
        logic [63:0] mwd;
        logic [63:0] npc;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{64'h00, enc_i(T_ADDI, 'hFFF, 31, 1), 1'b1, 5'd1,  64'hFFF, 1'b0, 64'h0, 64'h0, 64'h04},
        '{64'h04, enc_d(T_LD, 0, 31, 2),       1'b1, 5'd2,  64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 64'h0, 64'h0, 64'h08},
        '{64'h08, enc_i(T_ADDI, 16, 31, 4),    1'b1, 5'd4,  64'h10,  1'b0, 64'h0, 64'h0, 64'h0C},
        '{64'h0C, enc_d(T_LD, -8, 4, 3),       1'b1, 5'd3,  64'h7,   1'b0, 64'h0, 64'h0, 64'h10},
        '{64'h10, enc_r(T_SUB, 1, 3, 5),       1'b1, 5'd5,  64'hFFFF_FFFF_FFFF_F008, 1'b0, 64'h0, 64'h0, 64'h14},
        '{64'h14, enc_r(T_AND, 1, 2, 6),       1'b1, 5'd6,  64'hFF0,  1'b0, 64'h0, 64'h0, 64'h18},
        '{64'h18, enc_r(T_ORR, 1, 3, 7),       1'b1, 5'd7,  64'hFFF,  1'b0, 64'h0, 64'h0, 64'h1C},
        '{64'h1C, enc_i(T_SUBI, 7, 3, 8),      1'b1, 5'd8,  64'h0,   1'b0, 64'h0, 64'h0, 64'h20},
        '{64'h20, enc_r(T_ADD, 3, 1, 31),      1'b1, 5'd31, 64'h1006, 1'b0, 64'h0, 64'h0, 64'h24},
        '{64'h24, enc_r(T_ADD, 3, 31, 9),      1'b1, 5'd9,  64'h7,   1'b0, 64'h0, 64'h0, 64'h28},
        '{64'h28, enc_d(T_ST, 8, 4, 1),        1'b0, 5'd0,  64'h0,   1'b1, 64'h18, 64'hFFF, 64'h2C},
        '{64'h2C, enc_d(T_LD, 8, 4, 10),       1'b1, 5'd10, 64'hFFF, 1'b0, 64'h0, 64'h0, 64'h30},
        '{64'h30, 32'h0000_0000,               1'b0, 5'd0,  64'h0,   1'b0, 64'h0, 64'h0, 64'h34},
        '{64'h34, enc_cb(3, 7),                1'b0, 5'd0,  64'h0,   1'b0, 64'h0, 64'h0, 64'h38},
        '{64'h38, enc_cb(2, 8),                1'b0, 5'd0,  64'h0,   1'b0, 64'h0, 64'h0, 64'h40},
        '{64'h40, enc_b(2),                    1'b0, 5'd0,  64'h0,   1'b0, 64'h0, 64'h0, 64'h48},
        '{64'h48, enc_cb(4, 8),                1'b0, 5'd0,  64'h0,   1'b0, 64'h0, 64'h0, 64'h58},
        '{64'h58, enc_b(-3),                   1'b0, 5'd0,  64'h0,   1'b0, 64'h0, 64'h0, 64'h4C},
        '{64'h4C, enc_r(T_ADD, 9, 9, 11),      1'b1, 5'd11, 64'hE,   1'b0, 64'h0, 64'h0, 64'h50},
        '{64'h50, enc_b(0),                    1'b0, 5'd0,  64'h0,   1'b0, 64'h0, 64'h0, 64'h50}
    };

    localparam int NP = 14;
    localparam logic [31:0] PROG1 [NP] = '{
        enc_d(T_LD, 0, 31, 9),  enc_d(T_LD, 8, 31, 10), enc_d(T_LD, 16, 31, 11),
        enc_d(T_LD, 24, 31, 12), enc_d(T_LD, 32, 31, 13),
        enc_r(T_ORR, 11, 10, 10), enc_r(T_AND, 10, 12, 12), enc_cb(4, 12),
        enc_r(T_ADD, 9, 13, 13), enc_r(T_SUB, 9, 12, 12), enc_b(-3),
        enc_d(T_ST, 32, 31, 13), enc_d(T_LD, 32, 31, 13), enc_b(0)
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        prog_we, prog_dmem;
    logic [5:0]  prog_addr;
    logic [63:0] prog_data;
    logic [63:0] pc_o, next_pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [31:0] instr_o;
    logic        rf_we_o, dm_we_o;
    logic [4:0]  rf_waddr_o;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    sc_core64 i_sc_core64 (
        .clk(clk), .rst_n(rst_n),
        .prog_we_i(prog_we), .prog_dmem_i(prog_dmem), .prog_addr_i(prog_addr),
        .prog_data_i(prog_data),
        .pc_o(pc_o), .instr_o(instr_o), .next_pc_o(next_pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load(input bit to_dmem, input int addr, input logic [63:0] data);
        prog_we   = 1'b1;
        prog_dmem = to_dmem;
        prog_addr = addr[5:0];
        prog_data = data;
        @(negedge clk);
        prog_we   = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; prog_we = 1'b0; prog_dmem = 1'b0; prog_addr = '0; prog_data = '0;
        @(negedge clk);
        for (int k = 0; k < NV; k++) load(1'b0, int'(VEC[k].pc >> 2), 64'(VEC[k].ins));
        load(1'b1, 0, 64'hFFFF_FFFF_FFFF_FFF0);
        load(1'b1, 1, 64'h7);
        #0.5;
        chk("R1", "pc in reset", pc_o, 64'h0);
        chk("R1", "reg write in reset", 64'(rf_we_o), 64'h0);
        chk("R1", "mem write in reset", 64'(dm_we_o), 64'h0);

        // table walk: one row per executed instruction
        rst_n = 1'b1;
        #0.5;
        for (int k = 0; k < NV; k++) begin
            chk("R8", "pc", pc_o, VEC[k].pc);
            chk("R9 R10", "reg write enable", 64'(rf_we_o), 64'(VEC[k].we));
            chk("R6 R9 R10", "mem write enable", 64'(dm_we_o), 64'(VEC[k].mwe));
            if (VEC[k].we) begin
                chk("R3", "dest reg", 64'(rf_waddr_o), 64'(VEC[k].rd));
                chk("R2 R4 R5 R6 R7 R9", "write-back data", rf_wdata_o, VEC[k].wd);
            end
            if (VEC[k].mwe) begin
                chk("R6", "store address", dm_addr_o, VEC[k].maddr);
                chk("R3 R6", "store data", dm_wdata_o, VEC[k].mwd);
            end
            chk("R4 R8", "next pc", next_pc_o, VEC[k].npc);
            @(negedge clk);
            #0.5;
        end

        // mask-and-count program
        rst_n = 1'b0;
        @(negedge clk);
        for (int k = 0; k < NP; k++) load(1'b0, k, 64'(PROG1[k]));
        load(1'b1, 0, 64'h1);
        load(1'b1, 1, 64'hA);
        load(1'b1, 2, 64'h5);
        load(1'b1, 3, 64'h1234_5678_9ABC_EDFA);
        load(1'b1, 4, 64'h0);
        rst_n = 1'b1;
        #0.5;
        begin
            int  cyc = 0;
            bit  stored = 1'b0;
            while (pc_o != 64'h34 && cyc < 200) begin
                if (dm_we_o) begin
                    stored = 1'b1;
                    chk("R11", "count store address", dm_addr_o, 64'h20);
                    chk("R11", "count store data", dm_wdata_o, 64'hA);
                end
                if (pc_o == 64'h30) begin
                    chk("R11", "reload dest", 64'(rf_waddr_o), 64'd13);
                    chk("R11", "reload data", rf_wdata_o, 64'hA);
                end
                @(negedge clk);
                #0.5;
                cyc++;
            end
            chk("R11", "store seen", 64'(stored), 64'h1);
            chk("R11", "cycles to finish", 64'(cyc), 64'd50);
        end

        // reset mid-run clears pc and registers
        rst_n = 1'b0;
        #0.5;
        chk("R1", "pc after async reset", pc_o, 64'h0);
        @(negedge clk);
        load(1'b0, 0, 64'(enc_r(T_ORR, 12, 13, 1)));
        rst_n = 1'b1;
        #0.5;
        chk("R1", "registers cleared", rf_wdata_o, 64'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule